// File: doc/BRIEF.md
# Switch-Programmed Audio Frame Delay

This block delays a stream of 12-bit parallel audio words by a whole number of frames. Each word comes in with a one-cycle valid strobe. It is written into an on-chip circular buffer. The word written a programmed number of strobes earlier is read out at the same moment. The delay is set by two 4-bit rotary switch codes. The coarse code is worth sixteen fine steps. Together the two codes form an 8-bit step count, `coarse*16 + fine`. Each step is a fixed number of frames, so the delay in time follows the sample rate.

When both codes are zero, the block does not add zero steps. It takes a separate short fixed latency of `MIN_FRAMES` frames instead. The switch codes are synchronised and debounced before use. Only a code that stays steady for `DEB_CYC` cycles is applied. After reset, and after every delay change that is applied, the output is held at zero until the buffer holds the full programmed depth.

The default parameters use 4 frames per step, a 1024-word buffer, a 2-frame minimum path and a 16-cycle debounce. An audio build would use 96 frames per step with `ADDR_W` = 15. The parameters must always satisfy `255*STEP_FRAMES < 2**ADDR_W`.

Top module: `spd_frame_delay`

## Requirements
- R1: While reset is held and right after it, `outValid` is 0 and `outData` is 0.
- R2: `outValid` is 1 in exactly the clock cycle after each cycle with `inValid` = 1, and 0 after each cycle without it.
- R3: With both codes at 0, each output word equals the input word accepted `MIN_FRAMES` (default 2) strobes earlier.
- R4: With a nonzero code, the delay is `({coarseSel,fineSel})*STEP_FRAMES` strobes, so fine = 1 with coarse = 0 gives `STEP_FRAMES` (default 4) strobes.
- R5: Coarse = 1 with fine = 0 gives 16 fine steps, that is `16*STEP_FRAMES` (default 64) strobes.
- R6: Coarse = F with fine = F gives 255 steps, that is `255*STEP_FRAMES` (default 1020) strobes.
- R7: After reset or an applied delay change, the first N output words are 0, where N is the new delay in strobes.
- R8: A code change is applied only after the synchronised code has held steady for `DEB_CYC` cycles. A change that returns to the active code within that time has no effect on the output.
- R9: The write and read positions wrap modulo the buffer depth, and the delay stays exact across the wrap.
- R10: Cycles without `inValid` move neither position, so idle gaps do not change the delay counted in frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input word strobe |
| inData | input | DATA_W | Input audio word |
| coarseSel | input | 4 | Coarse delay code, 16 steps each |
| fineSel | input | 4 | Fine delay code, 1 step each |
| outValid | output | 1 | Output word strobe |
| outData | output | DATA_W | Delayed audio word, zero while muted |

## Verification
Every output word is due one clock after the edge that takes its input strobe. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge. It compares each word against a history of what it sent, indexed by the delay computed from the codes, with zero expected while the fill since the last change is below the delay.

A switch change takes effect at most `DEB_CYC`+3 cycles after the bench drives it. The bench therefore idles `DEB_CYC`+8 cycles after each change before sending more words. A glitch shorter than the debounce is followed by words that must continue unmuted at the old delay.

// File: rtl/spd_pkg.sv
package spd_pkg;

  // Per-word strobes from control to the datapath
  typedef struct packed {
    logic push;   // accept one word and advance the buffer
    logic mute;   // zero this word at the output
  } spd_strobe_t;

  // Delay in frames for a combined 8-bit step code
  function automatic int unsigned spd_frames(input logic [7:0] code,
                                             input int unsigned stepFrames,
                                             input int unsigned minFrames);
    if (code == 8'd0) return minFrames;
    return int'(code) * stepFrames;
  endfunction

endpackage

// File: rtl/spd_code_debounce.sv
module spd_code_debounce #(
  parameter int DEB_CYC = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] coarseIn,
  input  logic [3:0] fineIn,
  output logic [7:0] activeCode,
  output logic       reload
);
  localparam int CNT_W = $clog2(DEB_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEB_CYC);

  logic [7:0]       swQ;
  logic [7:0]       candCode;
  logic [CNT_W-1:0] stableCnt;

  assign reload = (stableCnt == CNT_MAX) && (candCode != activeCode);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swQ        <= '0;
      candCode   <= '0;
      stableCnt  <= '0;
      activeCode <= '0;
    end else begin
      swQ <= {coarseIn, fineIn};
      if (swQ != candCode) begin
        candCode  <= swQ;
        stableCnt <= '0;
      end else if (stableCnt != CNT_MAX) begin
        stableCnt <= stableCnt + 1'b1;
      end
      if (reload) activeCode <= candCode;
    end
  end

  // R8
  apply_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    reload |-> $stable(candCode));

  // R8
  active_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reload |=> $stable(activeCode));

endmodule

// File: rtl/spd_switch_ctrl.sv
module spd_switch_ctrl
  import spd_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int STEP_FRAMES = 4,
  parameter int MIN_FRAMES  = 2,
  parameter int DEB_CYC     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [3:0]        coarseIn,
  input  logic [3:0]        fineIn,
  output spd_strobe_t       strobes,
  output logic [ADDR_W-1:0] frames
);
  localparam int MAX_FRAMES = 255 * STEP_FRAMES;

  logic [7:0]        activeCode;
  logic              reload;
  logic [ADDR_W-1:0] fillCnt;

  spd_code_debounce #(.DEB_CYC(DEB_CYC)) uDeb (
    .clk        (clk),
    .rstN       (rstN),
    .coarseIn   (coarseIn),
    .fineIn     (fineIn),
    .activeCode (activeCode),
    .reload     (reload)
  );

  always_comb begin
    frames = ADDR_W'(spd_frames(activeCode, STEP_FRAMES, MIN_FRAMES));
  end

  // Fill count since reset or the last applied change, saturating at the delay
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt <= '0;
    end else if (reload) begin
      fillCnt <= '0;
    end else if (inValid && (fillCnt < frames)) begin
      fillCnt <= fillCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.push = inValid;
    strobes.mute = (fillCnt < frames);
  end

  // R4
  frames_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frames != '0) && (int'(frames) <= MAX_FRAMES));

  // R7
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fillCnt <= frames);

  // R7
  fill_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    reload |=> strobes.mute);

endmodule

// File: rtl/spd_delay_path.sv
module spd_delay_path
  import spd_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  spd_strobe_t       strobes,
  input  logic [ADDR_W-1:0] frames,
  input  logic [DATA_W-1:0] inData,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);
  localparam int DEPTH = 2 ** ADDR_W;
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] rdAddr;
  logic [DATA_W-1:0] rdQ;
  logic              muteQ;
  logic              validQ;

  assign rdAddr = wrPtr - frames;

  // Buffer: one write and one read per accepted word
  always_ff @(posedge clk) begin
    if (strobes.push) begin
      mem[wrPtr] <= inData;
      rdQ        <= mem[rdAddr];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      muteQ  <= 1'b1;
      validQ <= 1'b0;
    end else begin
      validQ <= strobes.push;
      if (strobes.push) begin
        wrPtr <= wrPtr + ONE;
        muteQ <= strobes.mute;
      end
    end
  end

  assign outValid = validQ;
  assign outData  = muteQ ? '0 : rdQ;

  // R9
  wr_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.push |=> wrPtr == $past(wrPtr) + ONE);

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.push |=> $stable(wrPtr));

  // R2
  out_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.push |=> outValid);

  // R7
  mute_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.push && strobes.mute) |=> outData == '0);

endmodule

// File: rtl/spd_frame_delay.sv
module spd_frame_delay
  import spd_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int ADDR_W      = 10,
  parameter int STEP_FRAMES = 4,
  parameter int MIN_FRAMES  = 2,
  parameter int DEB_CYC     = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic [3:0]        coarseSel,
  input  logic [3:0]        fineSel,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);
  spd_strobe_t       strobes;
  logic [ADDR_W-1:0] frames;

  spd_switch_ctrl #(
    .ADDR_W      (ADDR_W),
    .STEP_FRAMES (STEP_FRAMES),
    .MIN_FRAMES  (MIN_FRAMES),
    .DEB_CYC     (DEB_CYC)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .coarseIn (coarseSel),
    .fineIn   (fineSel),
    .strobes  (strobes),
    .frames   (frames)
  );

  spd_delay_path #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .frames   (frames),
    .inData   (inData),
    .outValid (outValid),
    .outData  (outData)
  );

  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: tb/tb_spd_frame_delay.sv
`timescale 1ns/1ps
module tb_spd_frame_delay;
  localparam int STEP  = 4;
  localparam int MINF  = 2;
  localparam int DEB   = 16;

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [11:0] inData;
  logic [3:0]  coarseSel;
  logic [3:0]  fineSel;
  logic        outValid;
  logic [11:0] outData;

  int vectors = 0;
  int errors  = 0;
  int pushIdx = 0;
  int sinceApply = 0;
  int curN = MINF;
  logic [11:0] hist [4096];

  always #5 clk = ~clk;

  spd_frame_delay #(
    .DATA_W(12), .ADDR_W(10), .STEP_FRAMES(STEP), .MIN_FRAMES(MINF), .DEB_CYC(DEB)
  ) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .coarseSel(coarseSel), .fineSel(fineSel),
    .outValid(outValid), .outData(outData)
  );

  task automatic checkEq(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pushOne(input string req);
    logic [11:0] d;
    logic [11:0] e;
    d = 12'(pushIdx * 37 + 11);
    hist[pushIdx] = d;
    e = (sinceApply < curN) ? 12'd0 : hist[pushIdx - curN];
    @(negedge clk);
    inValid = 1'b1;
    inData  = d;
    @(posedge clk);
    #1;
    checkEq({req, " valid"}, int'(outValid), 1);
    checkEq({req, " data"}, int'(outData), int'(e));
    pushIdx++;
    sinceApply++;
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      @(posedge clk);
      #1;
      checkEq({req, " idle valid"}, int'(outValid), 0);
    end
  endtask

  task automatic setCodes(input logic [3:0] c, input logic [3:0] f);
    int newN;
    newN = ({c, f} == 8'd0) ? MINF : int'({c, f}) * STEP;
    @(negedge clk);
    inValid   = 1'b0;
    coarseSel = c;
    fineSel   = f;
    idle(DEB + 8, "R8");
    if (newN != curN) sinceApply = 0;
    curN = newN;
  endtask

  // R1: reset state
  task automatic testReset();
    rstN = 1'b0; inValid = 1'b0; inData = '0; coarseSel = '0; fineSel = '0;
    repeat (4) @(posedge clk);
    #1;
    checkEq("R1 valid in reset", int'(outValid), 0);
    checkEq("R1 data in reset", int'(outData), 0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    checkEq("R1 valid after reset", int'(outValid), 0);
    checkEq("R1 data after reset", int'(outData), 0);
  endtask

  // R3 and R7: minimal path, first words muted
  task automatic testMinPath();
    for (int i = 0; i < 20; i++) pushOne("R3 min path");
    idle(2, "R2");
  endtask

  // R4 and R10: one fine step, stream with gaps
  task automatic testFineGaps();
    setCodes(4'h0, 4'h1);
    for (int i = 0; i < 30; i++) begin
      pushOne("R4 fine step");
      if (i % 3 == 1) idle(1 + (i % 4), "R10");
    end
    idle(1, "R2");
  endtask

  // R5: one coarse step equals sixteen fine steps
  task automatic testCoarse();
    setCodes(4'h1, 4'h0);
    for (int i = 0; i < 150; i++) pushOne("R5 coarse step");
    idle(1, "R2");
  endtask

  // R8: short glitch leaves the delay and fill untouched
  task automatic testGlitch();
    @(negedge clk);
    coarseSel = 4'h3;
    fineSel   = 4'h7;
    idle(4, "R8 glitch");
    @(negedge clk);
    coarseSel = 4'h1;
    fineSel   = 4'h0;
    idle(DEB + 8, "R8 settle");
    for (int i = 0; i < 10; i++) pushOne("R8 glitch ignored");
    idle(1, "R2");
  endtask

  // R6 and R9: maximum setting, stream past a buffer wrap
  task automatic testMaxWrap();
    setCodes(4'hF, 4'hF);
    for (int i = 0; i < 1100; i++) pushOne("R6 R9 max delay");
    idle(1, "R2");
  endtask

  // R3: return to the minimal path
  task automatic testBackToMin();
    setCodes(4'h0, 4'h0);
    for (int i = 0; i < 12; i++) pushOne("R3 back to min");
    idle(2, "R2");
  endtask

  initial begin
    testReset();
    testMinPath();
    testFineGaps();
    testCoarse();
    testGlitch();
    testMaxWrap();
    testBackToMin();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule